// File: doc/BRIEF.md
# Multi-Version Speculative Way Allocator

This block keeps the bookkeeping for one set of a shared, set-associative cache in which a line address may live in several ways at once: one committed copy that every requester sees, plus one private version for each live speculation ID that has written the line. Each way records a valid bit, a speculative flag, the owning speculation ID, the address tag, a small data payload and a recency rank.

A single request port carries reads and writes, each marked speculative or not and tagged with a speculation ID. A separate notification port commits or aborts all versions belonging to one ID. A commit promotes the ID's versions to committed and drops the stale committed copies they supersede. An abort discards them. Non-speculative fills may only occupy a bounded share of the set, so that the remaining ways stay available for speculative data. When a speculative write finds no way it may take, the block reports a capacity overflow carrying the writer's ID and drops that transaction's versions.

Top module: `mvw_set_alloc`

## Requirements
- R1: After reset the set is empty: `rd_valid` and `ovf_valid` are 0, and a read of any tag answers `rd_hit`=0 with `rd_data`=0.
- R2: A speculative write by ID i to tag t takes a new way only when i holds no version of t; a later speculative write by i to t overwrites that version in place and allocates nothing.
- R3: A speculative read by ID i returns i's own version of the tag when one exists and the committed copy otherwise; a non-speculative read returns only the committed copy; a miss answers `rd_hit`=0, `rd_data`=0.
- R4: A commit of ID i (`ntf_valid`=1, `ntf_abort`=0) turns every version of i into the committed copy of its tag and frees the older committed way of that tag in the same cycle.
- R5: An abort of ID i (`ntf_valid`=1, `ntf_abort`=1) invalidates every version of i; later reads see only the committed copy.
- R6: A non-speculative write that misses takes a free way only while fewer than NWAYS-SPEC_RESV (default 6) committed ways exist; otherwise it replaces a committed way, and it is dropped if the set holds no committed way.
- R7: The committed way replaced is the one least recently touched, where a write or a read hit touches a way and a read miss touches nothing.
- R8: A speculative write that needs a way takes a free way first, else replaces the least recently touched committed way, so more than SPEC_RESV speculative ways can coexist; speculative ways are never replaced.
- R9: When every way holds speculative data and a speculative write needs a new way, `ovf_valid` is 1 for exactly one cycle, in the cycle after the request, with `ovf_id` equal to the writer's ID; the write is dropped and all versions of that ID are invalidated.
- R10: A notification and a request in the same cycle are applied in order notification first: the request sees the set as the notification leaves it.
- R11: A read issued in one cycle is answered by `rd_valid`=1 with its result in the next cycle; writes produce no read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_spec | input | 1 | Request belongs to a speculative transaction |
| req_id | input | ID_W | Speculation ID of the requester |
| req_tag | input | TAG_W | Address tag of the line |
| req_wdata | input | DATA_W | Payload for writes |
| ntf_valid | input | 1 | Commit or abort notification present |
| ntf_abort | input | 1 | 1 = abort, 0 = commit |
| ntf_id | input | ID_W | Speculation ID being committed or aborted |
| rd_valid | output | 1 | Read result valid |
| rd_hit | output | 1 | Read found a visible version |
| rd_data | output | DATA_W | Read payload (0 on miss) |
| ovf_valid | output | 1 | Capacity overflow pulse |
| ovf_id | output | ID_W | Speculation ID that overflowed |

## Verification
The two functions that can meet in one cycle are the notification port and the request port acting on the same speculation ID. The bench provokes this by driving a speculative write of an ID together with that ID's commit, and a speculative read of an ID together with its abort. It judges the outcome by the reads that follow: the committed copy must carry the version that existed before the cycle, the new write must sit as a fresh private version, and the read paired with the abort must return the committed value.

// File: rtl/mvw_pkg.sv
package mvw_pkg;

  // What the request port does to the set in a given cycle
  typedef enum logic [1:0] {
    ACT_NONE     = 2'd0,
    ACT_UPDATE   = 2'd1,
    ACT_INSTALL  = 2'd2,
    ACT_OVERFLOW = 2'd3
  } req_act_e;

endpackage

// File: rtl/mvw_notify.sv
module mvw_notify #(
  parameter int NWAYS = 16,
  parameter int ID_W  = 7,
  parameter int TAG_W = 12
) (
  input  logic [NWAYS-1:0]            vld_i,
  input  logic [NWAYS-1:0]            spec_i,
  input  logic [NWAYS-1:0][ID_W-1:0]  id_i,
  input  logic [NWAYS-1:0][TAG_W-1:0] tag_i,
  input  logic                        ntf_valid,
  input  logic                        ntf_abort,
  input  logic [ID_W-1:0]             ntf_id,
  output logic [NWAYS-1:0]            vld_o,
  output logic [NWAYS-1:0]            spec_o
);

  logic [NWAYS-1:0] owned;

  always_comb begin
    for (int w = 0; w < NWAYS; w++) begin
      owned[w] = ntf_valid && vld_i[w] && spec_i[w] && (id_i[w] == ntf_id);
    end
  end

  always_comb begin
    vld_o  = vld_i;
    spec_o = spec_i;
    for (int w = 0; w < NWAYS; w++) begin
      if (owned[w]) begin
        if (ntf_abort) vld_o[w]  = 1'b0;
        else           spec_o[w] = 1'b0;
      end
    end
    // on commit, a committed way whose tag is being promoted becomes stale
    if (!ntf_abort) begin
      for (int v = 0; v < NWAYS; v++) begin
        for (int w = 0; w < NWAYS; w++) begin
          if (vld_i[v] && !spec_i[v] && owned[w] && (tag_i[w] == tag_i[v])) begin
            vld_o[v] = 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/mvw_pick.sv
module mvw_pick #(
  parameter int NWAYS = 16,
  parameter int ID_W  = 7,
  parameter int TAG_W = 12,
  localparam int IDX_W = $clog2(NWAYS),
  localparam int CNT_W = $clog2(NWAYS + 1)
) (
  input  logic [NWAYS-1:0]            vld_i,
  input  logic [NWAYS-1:0]            spec_i,
  input  logic [NWAYS-1:0][ID_W-1:0]  id_i,
  input  logic [NWAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [NWAYS-1:0][IDX_W-1:0] age_i,
  input  logic [ID_W-1:0]             req_id,
  input  logic [TAG_W-1:0]            req_tag,
  output logic                        own_hit,
  output logic [IDX_W-1:0]            own_idx,
  output logic                        cmt_hit,
  output logic [IDX_W-1:0]            cmt_idx,
  output logic                        free_any,
  output logic [IDX_W-1:0]            free_idx,
  output logic                        cmt_any,
  output logic [IDX_W-1:0]            lru_idx,
  output logic [CNT_W-1:0]            cmt_cnt
);

  logic [IDX_W-1:0] best_age;

  always_comb begin
    own_hit  = 1'b0;  own_idx  = '0;
    cmt_hit  = 1'b0;  cmt_idx  = '0;
    free_any = 1'b0;  free_idx = '0;
    // lowest index wins for hits and free ways
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (!vld_i[w]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(w);
      end
      if (vld_i[w] && spec_i[w] && (id_i[w] == req_id) && (tag_i[w] == req_tag)) begin
        own_hit = 1'b1;
        own_idx = IDX_W'(w);
      end
      if (vld_i[w] && !spec_i[w] && (tag_i[w] == req_tag)) begin
        cmt_hit = 1'b1;
        cmt_idx = IDX_W'(w);
      end
    end
  end

  always_comb begin
    cmt_any  = 1'b0;
    lru_idx  = '0;
    best_age = '0;
    cmt_cnt  = '0;
    for (int w = 0; w < NWAYS; w++) begin
      if (vld_i[w] && !spec_i[w]) begin
        cmt_cnt = cmt_cnt + CNT_W'(1);
        if (!cmt_any || (age_i[w] > best_age)) begin
          cmt_any  = 1'b1;
          lru_idx  = IDX_W'(w);
          best_age = age_i[w];
        end
      end
    end
  end

endmodule

// File: rtl/mvw_set_alloc.sv
module mvw_set_alloc
  import mvw_pkg::*;
#(
  parameter int NWAYS     = 16,
  parameter int SPEC_RESV = 10,
  parameter int TAG_W     = 12,
  parameter int ID_W      = 7,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_spec,
  input  logic [ID_W-1:0]   req_id,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ntf_valid,
  input  logic              ntf_abort,
  input  logic [ID_W-1:0]   ntf_id,
  output logic              rd_valid,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data,
  output logic              ovf_valid,
  output logic [ID_W-1:0]   ovf_id
);

  localparam int IDX_W   = $clog2(NWAYS);
  localparam int CNT_W   = $clog2(NWAYS + 1);
  localparam int CMT_MAX = NWAYS - SPEC_RESV;

  // way state
  logic [NWAYS-1:0]             vld_q, vld_d, spec_q, spec_d;
  logic [NWAYS-1:0][ID_W-1:0]   id_q, id_d;
  logic [NWAYS-1:0][TAG_W-1:0]  tag_q, tag_d;
  logic [NWAYS-1:0][DATA_W-1:0] data_q, data_d;
  logic [NWAYS-1:0][IDX_W-1:0]  age_q, age_d;

  // set after the notification has been applied
  logic [NWAYS-1:0] mid_vld, mid_spec;

  logic             own_hit, cmt_hit, free_any, cmt_any;
  logic [IDX_W-1:0] own_idx, cmt_idx, free_idx, lru_idx;
  logic [CNT_W-1:0] cmt_cnt;

  req_act_e         act;
  logic [IDX_W-1:0] tgt;
  logic             tch_en;
  logic [IDX_W-1:0] tch_idx;
  logic             rd_valid_d, rd_hit_d, ovf_valid_d;
  logic [DATA_W-1:0] rd_data_d;
  logic             st_en;

  mvw_notify #(.NWAYS(NWAYS), .ID_W(ID_W), .TAG_W(TAG_W)) u_notify (
    .vld_i(vld_q), .spec_i(spec_q), .id_i(id_q), .tag_i(tag_q),
    .ntf_valid(ntf_valid), .ntf_abort(ntf_abort), .ntf_id(ntf_id),
    .vld_o(mid_vld), .spec_o(mid_spec)
  );

  mvw_pick #(.NWAYS(NWAYS), .ID_W(ID_W), .TAG_W(TAG_W)) u_pick (
    .vld_i(mid_vld), .spec_i(mid_spec), .id_i(id_q), .tag_i(tag_q), .age_i(age_q),
    .req_id(req_id), .req_tag(req_tag),
    .own_hit(own_hit), .own_idx(own_idx), .cmt_hit(cmt_hit), .cmt_idx(cmt_idx),
    .free_any(free_any), .free_idx(free_idx), .cmt_any(cmt_any), .lru_idx(lru_idx),
    .cmt_cnt(cmt_cnt)
  );

  // request decision
  always_comb begin
    act        = ACT_NONE;
    tgt        = '0;
    rd_valid_d = 1'b0;
    rd_hit_d   = 1'b0;
    rd_data_d  = '0;
    tch_en     = 1'b0;
    tch_idx    = '0;
    if (req_valid && req_write && req_spec) begin
      if (own_hit)       begin act = ACT_UPDATE;  tgt = own_idx;  end
      else if (free_any) begin act = ACT_INSTALL; tgt = free_idx; end
      else if (cmt_any)  begin act = ACT_INSTALL; tgt = lru_idx;  end
      else                     act = ACT_OVERFLOW;
    end else if (req_valid && req_write) begin
      if (cmt_hit)                                  begin act = ACT_UPDATE;  tgt = cmt_idx;  end
      else if (free_any && (cmt_cnt < CNT_W'(CMT_MAX))) begin act = ACT_INSTALL; tgt = free_idx; end
      else if (cmt_any)                             begin act = ACT_INSTALL; tgt = lru_idx;  end
    end else if (req_valid) begin
      rd_valid_d = 1'b1;
      if (req_spec && own_hit) begin
        rd_hit_d = 1'b1; rd_data_d = data_q[own_idx]; tch_en = 1'b1; tch_idx = own_idx;
      end else if (cmt_hit) begin
        rd_hit_d = 1'b1; rd_data_d = data_q[cmt_idx]; tch_en = 1'b1; tch_idx = cmt_idx;
      end
    end
    if ((act == ACT_UPDATE) || (act == ACT_INSTALL)) begin
      tch_en  = 1'b1;
      tch_idx = tgt;
    end
  end

  assign ovf_valid_d = (act == ACT_OVERFLOW);
  assign st_en       = req_valid || ntf_valid;

  // next state of the ways
  always_comb begin
    vld_d  = mid_vld;
    spec_d = mid_spec;
    id_d   = id_q;
    tag_d  = tag_q;
    data_d = data_q;
    age_d  = age_q;
    case (act)
      ACT_UPDATE: data_d[tgt] = req_wdata;
      ACT_INSTALL: begin
        vld_d[tgt]  = 1'b1;
        spec_d[tgt] = req_spec;
        id_d[tgt]   = req_id;
        tag_d[tgt]  = req_tag;
        data_d[tgt] = req_wdata;
      end
      ACT_OVERFLOW: begin
        for (int w = 0; w < NWAYS; w++) begin
          if (mid_vld[w] && mid_spec[w] && (id_q[w] == req_id)) vld_d[w] = 1'b0;
        end
      end
      default: ;
    endcase
    if (tch_en) begin
      for (int w = 0; w < NWAYS; w++) begin
        if (IDX_W'(w) == tch_idx)            age_d[w] = '0;
        else if (age_q[w] < age_q[tch_idx])  age_d[w] = age_q[w] + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      spec_q <= '0;
      id_q   <= '0;
      tag_q  <= '0;
      data_q <= '0;
      for (int w = 0; w < NWAYS; w++) age_q[w] <= IDX_W'(w);
    end else if (st_en) begin
      vld_q  <= vld_d;
      spec_q <= spec_d;
      id_q   <= id_d;
      tag_q  <= tag_d;
      data_q <= data_d;
      age_q  <= age_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_hit    <= 1'b0;
      rd_data   <= '0;
      ovf_valid <= 1'b0;
      ovf_id    <= '0;
    end else begin
      rd_valid  <= rd_valid_d;
      rd_hit    <= rd_hit_d;
      rd_data   <= rd_data_d;
      ovf_valid <= ovf_valid_d;
      if (ovf_valid_d) ovf_id <= req_id;
    end
  end

  // ---------------- assertions ----------------
  logic owner_left;
  always_comb begin
    owner_left = 1'b0;
    for (int w = 0; w < NWAYS; w++) begin
      if (vld_q[w] && spec_q[w] && (id_q[w] == ovf_id)) owner_left = 1'b1;
    end
  end

  // R9: an overflow pulse follows a speculative write and leaves no version of its ID
  a_r9_ovf_from_spec_write: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_valid |-> $past(req_valid && req_write && req_spec));
  a_r9_owner_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_valid |-> !owner_left);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_valid && !$past(req_valid)) |-> 1'b0 || !ovf_valid);

  // R11: a response only follows a read
  a_r11_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write));
  a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_hit) |-> (rd_data == '0));

  generate
    for (genvar i = 0; i < NWAYS; i++) begin : g_pi
      for (genvar j = i + 1; j < NWAYS; j++) begin : g_pj
        // R2: one private version per ID and tag
        a_r2_one_version: assert property (@(posedge clk) disable iff (!rst_n)
          !(vld_q[i] && vld_q[j] && spec_q[i] && spec_q[j] &&
            (id_q[i] == id_q[j]) && (tag_q[i] == tag_q[j])));
        // R4: one committed copy per tag
        a_r4_one_committed: assert property (@(posedge clk) disable iff (!rst_n)
          !(vld_q[i] && vld_q[j] && !spec_q[i] && !spec_q[j] && (tag_q[i] == tag_q[j])));
        // R7: recency ranks stay distinct
        a_r7_rank_unique: assert property (@(posedge clk) disable iff (!rst_n)
          age_q[i] != age_q[j]);
      end
    end
  endgenerate

endmodule

// File: tb/mvw_set_alloc_bench.sv
module mvw_set_alloc_bench;

  localparam int ID_W = 7, TAG_W = 12, DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_spec;
  logic [ID_W-1:0] req_id;
  logic [TAG_W-1:0] req_tag;
  logic [DATA_W-1:0] req_wdata;
  logic ntf_valid, ntf_abort;
  logic [ID_W-1:0] ntf_id;
  logic rd_valid, rd_hit, ovf_valid;
  logic [DATA_W-1:0] rd_data;
  logic [ID_W-1:0] ovf_id;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic        q_hit[$];
  logic [7:0]  q_data[$];
  string       q_rd_req[$];
  logic [6:0]  q_ovf[$];
  string       q_ovf_req[$];

  always #4 clk = ~clk;

  mvw_set_alloc u_mvw_set_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_spec(req_spec), .req_id(req_id), .req_tag(req_tag), .req_wdata(req_wdata),
    .ntf_valid(ntf_valid), .ntf_abort(ntf_abort), .ntf_id(ntf_id),
    .rd_valid(rd_valid), .rd_hit(rd_hit), .rd_data(rd_data),
    .ovf_valid(ovf_valid), .ovf_id(ovf_id)
  );

  task automatic check(input bit ok, input string r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic drive(input bit rv, input bit rw, input bit rs, input logic [6:0] id,
                       input logic [11:0] tag, input logic [7:0] d,
                       input bit nv, input bit na, input logic [6:0] nid);
    @(negedge clk);
    req_valid = rv; req_write = rw; req_spec = rs; req_id = id; req_tag = tag; req_wdata = d;
    ntf_valid = nv; ntf_abort = na; ntf_id = nid;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input bit s, input logic [6:0] id, input logic [11:0] tag, input logic [7:0] d);
    drive(1, 1, s, id, tag, d, 0, 0, 0);
  endtask

  task automatic expect_rd(input bit h, input logic [7:0] d, input string r);
    q_hit.push_back(h); q_data.push_back(d); q_rd_req.push_back(r);
  endtask

  task automatic rd(input bit s, input logic [6:0] id, input logic [11:0] tag,
                    input bit h, input logic [7:0] d, input string r);
    drive(1, 0, s, id, tag, 0, 0, 0, 0);
    expect_rd(h, d, r);
  endtask

  task automatic ntf(input bit abort, input logic [6:0] id);
    drive(0, 0, 0, 0, 0, 0, 1, abort, id);
  endtask

  task automatic wr_ovf(input logic [6:0] id, input logic [11:0] tag, input string r);
    drive(1, 1, 1, id, tag, 8'hEE, 0, 0, 0);
    q_ovf.push_back(id); q_ovf_req.push_back(r);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    req_valid = 0; ntf_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        if (q_hit.size() == 0) begin
          check(0, "R11 unexpected read response", 16'(rd_data), 16'h0);
        end else begin
          logic h; logic [7:0] d; string r;
          h = q_hit.pop_front(); d = q_data.pop_front(); r = q_rd_req.pop_front();
          check((rd_hit == h) && (rd_data == d), r, {7'h0, rd_hit, rd_data}, {7'h0, h, d});
        end
      end
      if (ovf_valid) begin
        if (q_ovf.size() == 0) begin
          check(0, "R9 unexpected overflow", 16'(ovf_id), 16'h0);
        end else begin
          logic [6:0] e; string r;
          e = q_ovf.pop_front(); r = q_ovf_req.pop_front();
          check(ovf_id == e, r, 16'(ovf_id), 16'(e));
        end
      end
    end
  end

  task automatic drain(input string r);
    repeat (3) idle();
    check(q_hit.size() == 0, {r, " missing read responses"}, 16'(q_hit.size()), 16'h0);
    check(q_ovf.size() == 0, {r, " missing overflow pulses"}, 16'(q_ovf.size()), 16'h0);
  endtask

  initial begin
    rst_n = 0;
    req_valid = 0; req_write = 0; req_spec = 0; req_id = 0; req_tag = 0; req_wdata = 0;
    ntf_valid = 0; ntf_abort = 0; ntf_id = 0;
    repeat (3) @(negedge clk);
    check(rd_valid == 0, "R1 rd_valid in reset", 16'(rd_valid), 16'h0);
    check(ovf_valid == 0, "R1 ovf_valid in reset", 16'(ovf_valid), 16'h0);
    rst_n = 1;

    // R1: empty after reset
    rd(0, 0, 12'h011, 0, 8'h00, "R1 empty set read");
    // committed write and read
    wr(0, 0, 12'h011, 8'h11);
    rd(0, 0, 12'h011, 1, 8'h11, "R3 committed read");
    // R2/R3: private version
    wr(1, 5, 12'h011, 8'h55);
    rd(1, 5, 12'h011, 1, 8'h55, "R3 own version");
    rd(1, 6, 12'h011, 1, 8'h11, "R3 other id sees committed");
    rd(0, 0, 12'h011, 1, 8'h11, "R3 nonspec sees committed");
    // R4: commit promotes and frees stale copy
    ntf(0, 5);
    rd(0, 0, 12'h011, 1, 8'h55, "R4 committed after commit");
    rd(1, 5, 12'h011, 1, 8'h55, "R4 id sees promoted copy");
    // R5: abort
    wr(1, 7, 12'h012, 8'h77);
    rd(1, 7, 12'h012, 1, 8'h77, "R3 own new line");
    ntf(1, 7);
    rd(1, 7, 12'h012, 0, 8'h00, "R5 aborted version gone");
    rd(0, 0, 12'h012, 0, 8'h00, "R5 no committed copy");
    // R10: same-cycle notification and request
    wr(1, 9, 12'h013, 8'h90);
    drive(1, 1, 1, 9, 12'h013, 8'h91, 1, 0, 9);
    rd(0, 0, 12'h013, 1, 8'h90, "R10 commit before write committed value");
    rd(1, 9, 12'h013, 1, 8'h91, "R10 write after commit is private");
    drive(1, 0, 1, 9, 12'h013, 0, 1, 1, 9);
    expect_rd(1, 8'h90, "R10 read after same-cycle abort");
    drain("R11");

    // LRU, reservation, overflow
    do_reset();
    for (int i = 0; i < 6; i++) wr(0, 0, 12'h020 + 12'(i), 8'hA0 + 8'(i));
    rd(0, 0, 12'h020, 1, 8'hA0, "R7 touch oldest");
    wr(0, 0, 12'h026, 8'hA6);
    rd(0, 0, 12'h021, 0, 8'h00, "R6 reserved ways force eviction");
    rd(0, 0, 12'h020, 1, 8'hA0, "R7 touched line kept");
    rd(0, 0, 12'h026, 1, 8'hA6, "R6 new line present");
    for (int i = 1; i <= 10; i++) wr(1, 7'(i), 12'h040 + 12'(i), 8'h10 + 8'(i));
    wr(1, 11, 12'h04B, 8'h1B);
    rd(0, 0, 12'h022, 0, 8'h00, "R8 spec write evicts LRU committed");
    rd(0, 0, 12'h023, 1, 8'hA3, "R7 next committed still there");
    rd(1, 1, 12'h041, 1, 8'h11, "R8 spec way not evicted");
    for (int i = 12; i <= 15; i++) wr(1, 7'(i), 12'h040 + 12'(i), 8'h10 + 8'(i));
    wr(1, 16, 12'h050, 8'h50);
    rd(0, 0, 12'h026, 0, 8'h00, "R8 last committed evicted");
    rd(1, 15, 12'h04F, 1, 8'h1F, "R8 sixteen spec ways held");
    wr_ovf(16, 12'h051, "R9 overflow id 16");
    rd(1, 16, 12'h050, 0, 8'h00, "R9 owner versions invalidated");
    rd(1, 16, 12'h051, 0, 8'h00, "R9 overflowing write dropped");
    wr(1, 3, 12'h043, 8'h33);
    rd(1, 3, 12'h043, 1, 8'h33, "R2 in-place update");
    wr(1, 17, 12'h060, 8'h60);
    rd(1, 17, 12'h060, 1, 8'h60, "R2 freed way reused");
    wr_ovf(18, 12'h061, "R2 update took no way so set is full");
    rd(1, 4, 12'h044, 1, 8'h14, "R9 other ids untouched");
    drain("R9");

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule